// File: doc/BRIEF.md
# Byte-Wide Indirect Access Window

This block gives a host with an 8-bit I/O bus access to two 32-bit internal targets: a register space addressed by word index, and a memory split into four pages. The host loads an address and four data bytes through byte registers, and a write to the top data byte starts a 32-bit write. Setting the start bit of a control byte fetches a 32-bit word into four read-back bytes. Each control byte reports whether the last write has finished and whether the read-back bytes are valid. The register-side control byte also reports whether the internal core is ready.

A single sequencer drives both internal ports through a request/acknowledge handshake, and the target may insert any number of wait cycles. Only one request is outstanding at a time. Requests made while the sequencer is busy are held as pending and issued later in a fixed priority order. A coverage byte keeps sticky flags for each kind of access, and it records only while its enable bit is set.

Top module: `hostwin_bridge`

## Requirements
- R1: The register index byte (offset 0x00) is put on `int_addr` unchanged, with no division by four. A host write to offset 0x05 starts a register write whose data is {byte@0x05, byte@0x04, byte@0x03, byte@0x02}, so byte 0x02 carries bits 7:0.
- R2: In a register write, `int_be[3]` is always 1. `int_be[k]` for k = 0..2 is 1 only if byte 0x02+k was written since the previous register write was issued. Memory writes use `int_be` = 4'hF.
- R3: Register control byte 0x01 reads {core_rdy, 5'b0, write_done, read_valid}. Memory control byte 0x0C reads {6'b0, write_done, read_valid}.
- R4: In each control byte, write_done (bit 1) is 1 after reset. It reads 0 from the cycle after a write is started until the internal port acknowledges that write, and 1 again after that.
- R5: Writing a control byte with bit 0 set starts a read. Read_valid (bit 0) is 0 after reset and from the start of the read until its acknowledge. After that the read-back bytes hold the returned word: 0x06..0x09 for registers and 0x11..0x14 for memory, lowest byte first.
- R6: The memory location is page × 2048 + (address mod 2048). The page is bits 1:0 of offset 0x15, the address is {0x0B, 0x0A}, a memory write is started by a write to 0x10, and its data bytes are 0x0D..0x10.
- R7: Only one internal request is active at a time, and `rg_req` and `mm_req` are never both high. A request stays high with stable address and data until its acknowledge. A request made while the sequencer is busy is held until it can be issued.
- R8: When several requests are pending and the sequencer is idle, they are issued in this order: register write, register read, memory write, memory read.
- R9: Coverage byte 0x16 reads {flags[7:1], enable}. Enable is bit 0 and can be written. Flags and enable are 0 after reset. Flags stay set once set, and host writes to bits 7:1 have no effect.
- R10: Coverage flags change only while enable is 1.
- R11: The flag bits mean: 7 host read strobe, 6 host write strobe, 5 memory read issued, 4 register read issued, 3 register write issued with any lane disabled, 2 memory write issued, 1 register write issued with all lanes enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_we | input | 1 | Host write strobe |
| hst_re | input | 1 | Host read strobe (used only for coverage) |
| hst_addr | input | 5 | Host byte offset |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte (combinational on hst_addr) |
| core_rdy | input | 1 | Internal core is out of reset |
| rg_req | output | 1 | Register port request |
| rg_ack | input | 1 | Register port acknowledge |
| rg_rdata | input | 32 | Register port read word |
| mm_req | output | 1 | Memory port request |
| mm_ack | input | 1 | Memory port acknowledge |
| mm_rdata | input | 32 | Memory port read word |
| int_we | output | 1 | Shared: request is a write |
| int_addr | output | IADDR_W (13) | Shared word address / memory location |
| int_wdata | output | 32 | Shared write word |
| int_be | output | 4 | Shared byte-lane enables |

## Verification
The bench builds the block with its default values, PAGE_W = 2 and LOC_W = 11, which give a 13-bit location space of 8192 words. With these values every page can be reached, including the last location 8191 and the wrap of address bits above bit 10. The responder's wait count is set per transaction from zero to six cycles. This covers back-to-back completion, long holds in which three further requests pile up behind an active one, and partial-lane register writes whose effect is read back through the register port.

// File: rtl/hwin_pkg.sv
package hwin_pkg;
    localparam int OFS_W = 5;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int LANES = WORD_W / BYTE_W;
    localparam int NKIND = 4;

    localparam logic [OFS_W-1:0] OFS_RIDX = 5'h00;
    localparam logic [OFS_W-1:0] OFS_RCTL = 5'h01;
    localparam logic [OFS_W-1:0] OFS_RWD0 = 5'h02;
    localparam logic [OFS_W-1:0] OFS_RRD0 = 5'h06;
    localparam logic [OFS_W-1:0] OFS_MADL = 5'h0A;
    localparam logic [OFS_W-1:0] OFS_MADH = 5'h0B;
    localparam logic [OFS_W-1:0] OFS_MCTL = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_MWD0 = 5'h0D;
    localparam logic [OFS_W-1:0] OFS_MRD0 = 5'h11;
    localparam logic [OFS_W-1:0] OFS_PAGE = 5'h15;
    localparam logic [OFS_W-1:0] OFS_COV  = 5'h16;

    // transaction kinds, index order is issue priority
    localparam int KI_RWR = 0;
    localparam int KI_RRD = 1;
    localparam int KI_MWR = 2;
    localparam int KI_MRD = 3;
endpackage

// File: rtl/hwin_regs.sv
module hwin_regs
    import hwin_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int LOC_W = 11,
    localparam int MADDR_W = PAGE_W + LOC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hst_we,
    input  logic [OFS_W-1:0]     hst_addr,
    input  logic [BYTE_W-1:0]    hst_wdata,
    output logic [BYTE_W-1:0]    hst_rdata,
    input  logic                 core_rdy,
    input  logic [BYTE_W-1:0]    cov_byte,
    input  logic [NKIND-1:0]     grant,
    input  logic [NKIND-1:0]     act,
    input  logic [NKIND-1:0]     cmpl,
    input  logic [WORD_W-1:0]    cmpl_data,
    output logic [NKIND-1:0]     pend,
    output logic [BYTE_W-1:0]    reg_idx,
    output logic [WORD_W-1:0]    reg_wd,
    output logic [LANES-1:0]     reg_be,
    output logic [MADDR_W-1:0]   mem_loc,
    output logic [WORD_W-1:0]    mem_wd
);
    typedef struct packed {
        logic [BYTE_W-1:0]   ridx;
        logic [WORD_W-1:0]   rwd;
        logic [LANES-2:0]    lanes;
        logic [WORD_W-1:0]   rrd;
        logic                rrv;
        logic [2*BYTE_W-1:0] madr;
        logic [WORD_W-1:0]   mwd;
        logic [WORD_W-1:0]   mrd;
        logic                mrv;
        logic [PAGE_W-1:0]   page;
        logic [NKIND-1:0]    pend;
    } regs_t;

    regs_t s_d, s_q;
    logic [NKIND-1:0] trig;
    logic rwr_done, mwr_done;

    always_comb begin
        s_d = s_q;
        trig = '0;
        s_d.lanes = grant[KI_RWR] ? '0 : s_q.lanes;
        if (hst_we) begin
            if (hst_addr == OFS_RIDX) s_d.ridx = hst_wdata;
            if (hst_addr == OFS_RCTL) trig[KI_RRD] = hst_wdata[0];
            if (hst_addr == OFS_MADL) s_d.madr[BYTE_W-1:0] = hst_wdata;
            if (hst_addr == OFS_MADH) s_d.madr[2*BYTE_W-1:BYTE_W] = hst_wdata;
            if (hst_addr == OFS_MCTL) trig[KI_MRD] = hst_wdata[0];
            if (hst_addr == OFS_PAGE) s_d.page = hst_wdata[PAGE_W-1:0];
            for (int b = 0; b < LANES; b++) begin
                if (hst_addr == OFS_RWD0 + OFS_W'(b)) begin
                    s_d.rwd[BYTE_W*b +: BYTE_W] = hst_wdata;
                    if (b == LANES-1) trig[KI_RWR] = 1'b1;
                    else              s_d.lanes[b] = 1'b1;
                end
                if (hst_addr == OFS_MWD0 + OFS_W'(b)) begin
                    s_d.mwd[BYTE_W*b +: BYTE_W] = hst_wdata;
                    if (b == LANES-1) trig[KI_MWR] = 1'b1;
                end
            end
        end
        s_d.pend = (s_q.pend & ~grant) | trig;
        if (cmpl[KI_RRD]) s_d.rrd = cmpl_data;
        if (cmpl[KI_MRD]) s_d.mrd = cmpl_data;
        if (trig[KI_RRD]) s_d.rrv = 1'b0;
        else if (cmpl[KI_RRD] && !s_q.pend[KI_RRD]) s_d.rrv = 1'b1;
        if (trig[KI_MRD]) s_d.mrv = 1'b0;
        else if (cmpl[KI_MRD] && !s_q.pend[KI_MRD]) s_d.mrv = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rwr_done = !(s_q.pend[KI_RWR] || act[KI_RWR]);
    assign mwr_done = !(s_q.pend[KI_MWR] || act[KI_MWR]);

    always_comb begin
        hst_rdata = '0;
        if (hst_addr == OFS_RIDX) hst_rdata = s_q.ridx;
        if (hst_addr == OFS_RCTL) hst_rdata = {core_rdy, 5'b0, rwr_done, s_q.rrv};
        if (hst_addr == OFS_MADL) hst_rdata = s_q.madr[BYTE_W-1:0];
        if (hst_addr == OFS_MADH) hst_rdata = s_q.madr[2*BYTE_W-1:BYTE_W];
        if (hst_addr == OFS_MCTL) hst_rdata = {6'b0, mwr_done, s_q.mrv};
        if (hst_addr == OFS_PAGE) hst_rdata = {{(BYTE_W-PAGE_W){1'b0}}, s_q.page};
        if (hst_addr == OFS_COV)  hst_rdata = cov_byte;
        for (int b = 0; b < LANES; b++) begin
            if (hst_addr == OFS_RWD0 + OFS_W'(b)) hst_rdata = s_q.rwd[BYTE_W*b +: BYTE_W];
            if (hst_addr == OFS_RRD0 + OFS_W'(b)) hst_rdata = s_q.rrd[BYTE_W*b +: BYTE_W];
            if (hst_addr == OFS_MWD0 + OFS_W'(b)) hst_rdata = s_q.mwd[BYTE_W*b +: BYTE_W];
            if (hst_addr == OFS_MRD0 + OFS_W'(b)) hst_rdata = s_q.mrd[BYTE_W*b +: BYTE_W];
        end
    end

    assign pend    = s_q.pend;
    assign reg_idx = s_q.ridx;
    assign reg_wd  = s_q.rwd;
    assign reg_be  = {1'b1, s_q.lanes};
    assign mem_loc = {s_q.page, s_q.madr[LOC_W-1:0]};
    assign mem_wd  = s_q.mwd;

    AST_WDONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_we && hst_addr == OFS_RWD0 + OFS_W'(LANES-1)) |=> !rwr_done); // R4
    AST_RV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl[KI_RRD] && !s_q.pend[KI_RRD] && !trig[KI_RRD])
        |=> (s_q.rrv && s_q.rrd == $past(cmpl_data))); // R5
endmodule

// File: rtl/hwin_seq.sv
module hwin_seq
    import hwin_pkg::*;
#(
    parameter int IADDR_W = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NKIND-1:0]     pend,
    input  logic [IADDR_W-1:0]   reg_addr,
    input  logic [IADDR_W-1:0]   mem_addr,
    input  logic [WORD_W-1:0]    reg_wd,
    input  logic [WORD_W-1:0]    mem_wd,
    input  logic [LANES-1:0]     reg_be,
    input  logic                 rg_ack,
    input  logic [WORD_W-1:0]    rg_rdata,
    input  logic                 mm_ack,
    input  logic [WORD_W-1:0]    mm_rdata,
    output logic [NKIND-1:0]     grant,
    output logic [NKIND-1:0]     act,
    output logic [NKIND-1:0]     cmpl,
    output logic [WORD_W-1:0]    cmpl_data,
    output logic                 rg_req,
    output logic                 mm_req,
    output logic                 int_we,
    output logic [IADDR_W-1:0]   int_addr,
    output logic [WORD_W-1:0]    int_wdata,
    output logic [LANES-1:0]     int_be
);
    typedef struct packed {
        logic [NKIND-1:0]   act;
        logic [IADDR_W-1:0] addr;
        logic [WORD_W-1:0]  wd;
        logic [LANES-1:0]   be;
    } seq_t;

    seq_t s_d, s_q;
    logic is_rg, is_mm, ack_now;

    assign is_rg   = s_q.act[KI_RWR] | s_q.act[KI_RRD];
    assign is_mm   = s_q.act[KI_MWR] | s_q.act[KI_MRD];
    assign ack_now = (is_rg & rg_ack) | (is_mm & mm_ack);

    always_comb begin
        s_d = s_q;
        grant = '0;
        if (s_q.act == '0) begin
            for (int k = 0; k < NKIND; k++) begin
                if (pend[k] && grant == '0) grant[k] = 1'b1;
            end
        end
        if (ack_now) s_d.act = '0;
        if (grant != '0) begin
            s_d.act  = grant;
            s_d.addr = (grant[KI_RWR] | grant[KI_RRD]) ? reg_addr : mem_addr;
            s_d.wd   = grant[KI_RWR] ? reg_wd : mem_wd;
            s_d.be   = grant[KI_RWR] ? reg_be : '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act       = s_q.act;
    assign cmpl      = ack_now ? s_q.act : '0;
    assign cmpl_data = is_rg ? rg_rdata : mm_rdata;
    assign rg_req    = is_rg;
    assign mm_req    = is_mm;
    assign int_we    = s_q.act[KI_RWR] | s_q.act[KI_MWR];
    assign int_addr  = s_q.addr;
    assign int_wdata = s_q.wd;
    assign int_be    = s_q.be;

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(rg_req && mm_req)); // R7
    AST_RG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_req && !rg_ack) |=> (rg_req && $stable(int_addr) && $stable(int_wdata) && $stable(int_we))); // R7
    AST_MM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_req && !mm_ack) |=> (mm_req && $stable(int_addr) && $stable(int_wdata) && $stable(int_we))); // R7
    AST_PRIO_RWR: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act == '0 && pend[KI_RWR]) |=> (rg_req && int_we)); // R8
endmodule

// File: rtl/hwin_cov.sv
module hwin_cov
    import hwin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hst_we,
    input  logic                 hst_re,
    input  logic [OFS_W-1:0]     hst_addr,
    input  logic [BYTE_W-1:0]    hst_wdata,
    input  logic [NKIND-1:0]     grant,
    input  logic [LANES-1:0]     reg_be,
    output logic [BYTE_W-1:0]    cov_byte
);
    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:1] flags;
    } cov_t;

    cov_t s_d, s_q;
    logic [BYTE_W-1:1] ev;
    logic full_lanes;

    assign full_lanes = &reg_be;
    assign ev = {hst_re, hst_we, grant[KI_MRD], grant[KI_RRD],
                 grant[KI_RWR] & ~full_lanes, grant[KI_MWR],
                 grant[KI_RWR] & full_lanes};

    always_comb begin
        s_d = s_q;
        if (hst_we && hst_addr == OFS_COV) s_d.en = hst_wdata[0];
        if (s_q.en) s_d.flags = s_q.flags | ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cov_byte = {s_q.flags, s_q.en};

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.flags & $past(s_q.flags)) == $past(s_q.flags))); // R9
    AST_NO_REC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.en |=> $stable(s_q.flags)); // R10
endmodule

// File: rtl/hostwin_bridge.sv
module hostwin_bridge
    import hwin_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int LOC_W = 11,
    localparam int MADDR_W = PAGE_W + LOC_W,
    localparam int IADDR_W = (MADDR_W > BYTE_W) ? MADDR_W : BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hst_we,
    input  logic                 hst_re,
    input  logic [OFS_W-1:0]     hst_addr,
    input  logic [BYTE_W-1:0]    hst_wdata,
    output logic [BYTE_W-1:0]    hst_rdata,
    input  logic                 core_rdy,
    output logic                 rg_req,
    input  logic                 rg_ack,
    input  logic [WORD_W-1:0]    rg_rdata,
    output logic                 mm_req,
    input  logic                 mm_ack,
    input  logic [WORD_W-1:0]    mm_rdata,
    output logic                 int_we,
    output logic [IADDR_W-1:0]   int_addr,
    output logic [WORD_W-1:0]    int_wdata,
    output logic [LANES-1:0]     int_be
);
    logic [NKIND-1:0]   grant, act, cmpl, pend;
    logic [WORD_W-1:0]  cmpl_data, reg_wd, mem_wd;
    logic [BYTE_W-1:0]  reg_idx, cov_byte;
    logic [LANES-1:0]   reg_be;
    logic [MADDR_W-1:0] mem_loc;

    hwin_regs #(.PAGE_W(PAGE_W), .LOC_W(LOC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .core_rdy(core_rdy),
        .cov_byte(cov_byte), .grant(grant), .act(act), .cmpl(cmpl),
        .cmpl_data(cmpl_data), .pend(pend), .reg_idx(reg_idx), .reg_wd(reg_wd),
        .reg_be(reg_be), .mem_loc(mem_loc), .mem_wd(mem_wd)
    );

    hwin_seq #(.IADDR_W(IADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .pend(pend),
        .reg_addr(IADDR_W'(reg_idx)), .mem_addr(IADDR_W'(mem_loc)),
        .reg_wd(reg_wd), .mem_wd(mem_wd), .reg_be(reg_be),
        .rg_ack(rg_ack), .rg_rdata(rg_rdata), .mm_ack(mm_ack), .mm_rdata(mm_rdata),
        .grant(grant), .act(act), .cmpl(cmpl), .cmpl_data(cmpl_data),
        .rg_req(rg_req), .mm_req(mm_req), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_be(int_be)
    );

    hwin_cov u_cov (
        .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_re(hst_re),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .grant(grant),
        .reg_be(reg_be), .cov_byte(cov_byte)
    );
endmodule

// File: tb/test_hostwin_bridge.sv
`timescale 1ns/100ps
module test_hostwin_bridge;
    import hwin_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hst_we = 1'b0, hst_re = 1'b0, core_rdy = 1'b0;
    logic [4:0] hst_addr = '0;
    logic [7:0] hst_wdata = '0, hst_rdata;
    logic rg_req, mm_req, int_we;
    logic rg_ack = 1'b0, mm_ack = 1'b0;
    logic [31:0] rg_rdata = '0, mm_rdata = '0, int_wdata;
    logic [12:0] int_addr;
    logic [3:0] int_be;

    always #2 clk = ~clk;

    hostwin_bridge i_hostwin_bridge (
        .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_re(hst_re),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .core_rdy(core_rdy), .rg_req(rg_req), .rg_ack(rg_ack), .rg_rdata(rg_rdata),
        .mm_req(mm_req), .mm_ack(mm_ack), .mm_rdata(mm_rdata), .int_we(int_we),
        .int_addr(int_addr), .int_wdata(int_wdata), .int_be(int_be)
    );

    int nchk = 0, nerr = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct {
        bit          we;
        int          addr;
        logic [31:0] data;
        logic [3:0]  be;
        string       tag;
    } txn_t;

    txn_t rgq[$], mmq[$];
    int kind_log[$];
    logic [31:0] rf [0:255];
    logic [31:0] mm [0:8191];
    int rg_wait_cfg = 0, mm_wait_cfg = 0, rg_cnt = -1, mm_cnt = -1;
    int rg_cmpl = 0, mm_cmpl = 0;

    // behavioural targets: accept requests after a set number of wait cycles
    always @(negedge clk) begin
        if (rst_n) begin
            if (rg_req && mm_req) chk(1'b0, "R7 overlapping requests", 32'd1, 32'd0);
            if (rg_ack) begin
                rg_ack <= 1'b0;
                rg_cmpl++;
            end else if (rg_req) begin
                if (rg_cnt < 0) rg_cnt = rg_wait_cfg;
                if (rg_cnt == 0) begin
                    txn_t t;
                    kind_log.push_back(int_we ? KI_RWR : KI_RRD);
                    if (rgq.size() == 0) chk(1'b0, "R7 unexpected register request", int_addr, 0);
                    else begin
                        t = rgq.pop_front();
                        chk(int_we == t.we && int_addr == 13'(t.addr), t.tag, {19'd0, int_addr}, t.addr);
                        if (t.we) chk(int_wdata == t.data && int_be == t.be, t.tag, int_wdata, t.data);
                    end
                    rg_rdata <= rf[int_addr[7:0]];
                    if (int_we)
                        for (int b = 0; b < 4; b++)
                            if (int_be[b]) rf[int_addr[7:0]][8*b +: 8] = int_wdata[8*b +: 8];
                    rg_ack <= 1'b1;
                    rg_cnt = -1;
                end else rg_cnt--;
            end
            if (mm_ack) begin
                mm_ack <= 1'b0;
                mm_cmpl++;
            end else if (mm_req) begin
                if (mm_cnt < 0) mm_cnt = mm_wait_cfg;
                if (mm_cnt == 0) begin
                    txn_t t;
                    kind_log.push_back(int_we ? KI_MWR : KI_MRD);
                    if (mmq.size() == 0) chk(1'b0, "R7 unexpected memory request", int_addr, 0);
                    else begin
                        t = mmq.pop_front();
                        chk(int_we == t.we && int_addr == 13'(t.addr), t.tag, {19'd0, int_addr}, t.addr);
                        if (t.we) chk(int_wdata == t.data && int_be == t.be, t.tag, int_wdata, t.data);
                    end
                    mm_rdata <= mm[int_addr];
                    if (int_we) mm[int_addr] = int_wdata;
                    mm_ack <= 1'b1;
                    mm_cnt = -1;
                end else mm_cnt--;
            end
        end
    end

    task automatic hwr(input logic [4:0] a, input logic [7:0] d);
        hst_addr = a; hst_wdata = d; hst_we = 1'b1;
        @(negedge clk);
        hst_we = 1'b0;
    endtask

    task automatic hrd(input logic [4:0] a, output logic [7:0] d);
        hst_addr = a; hst_re = 1'b1;
        #0.5 d = hst_rdata;
        @(negedge clk);
        hst_re = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        hst_addr = a;
        #0.5 d = hst_rdata;
    endtask

    task automatic rd_word(input logic [4:0] base, output logic [31:0] w);
        for (int b = 0; b < 4; b++) begin
            logic [7:0] v;
            hrd(base + 5'(b), v);
            w[8*b +: 8] = v;
        end
    endtask

    task automatic poll(input bit mem, input int bitn, input int target, input string tag);
        for (int i = 0; i < 60; i++) begin
            logic [7:0] v;
            bit e;
            peek(mem ? OFS_MCTL : OFS_RCTL, v);
            e = ((mem ? mm_cmpl : rg_cmpl) >= target);
            chk(v[bitn] == e, tag, {31'd0, v[bitn]}, {31'd0, e});
            @(negedge clk);
            if (e) break;
        end
    endtask

    task automatic cov_is(input logic [7:0] e, input string tag);
        logic [7:0] v;
        peek(OFS_COV, v);
        chk(v == e, tag, {24'd0, v}, {24'd0, e});
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [31:0] w;
        for (int i = 0; i < 256; i++) rf[i] = 32'hC0DE0000 | i;
        for (int i = 0; i < 8192; i++) mm[i] = 32'h5A000000 | (i * 7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        peek(OFS_RCTL, v); chk(v == 8'h02, "R3 R4 R5 reset register control", v, 8'h02); @(negedge clk);
        peek(OFS_MCTL, v); chk(v == 8'h02, "R4 R5 reset memory control", v, 8'h02); @(negedge clk);
        cov_is(8'h00, "R9 reset coverage");
        core_rdy = 1'b1; @(negedge clk);
        peek(OFS_RCTL, v); chk(v == 8'h82, "R3 core ready bit", v, 8'h82); @(negedge clk);

        // full-lane register write with coverage disabled
        rg_wait_cfg = 2;
        rgq.push_back('{1, 2, 32'h04030201, 4'hF, "R1 write idx2"});
        hwr(OFS_RIDX, 8'h02);
        for (int b = 0; b < 4; b++) hwr(OFS_RWD0 + 5'(b), 8'(b + 1));
        poll(0, 1, rg_cmpl + 1, "R4 register write done");
        cov_is(8'h00, "R10 no recording while disabled");
        hwr(OFS_COV, 8'hFF);
        cov_is(8'h01, "R9 only enable bit writable");

        // full-lane register write at index 5
        rg_wait_cfg = 3;
        rgq.push_back('{1, 5, 32'h44332211, 4'hF, "R1 write idx5 full lanes"});
        hwr(OFS_RIDX, 8'h05);
        hwr(OFS_RWD0, 8'h11); hwr(OFS_RWD0 + 5'd1, 8'h22);
        hwr(OFS_RWD0 + 5'd2, 8'h33); hwr(OFS_RWD0 + 5'd3, 8'h44);
        poll(0, 1, rg_cmpl + 1, "R4 register write done wait 3");
        cov_is(8'h43, "R11 host write and full-lane flags");

        // register read back
        rg_wait_cfg = 0;
        rgq.push_back('{0, 5, 0, 0, "R1 read idx5"});
        hwr(OFS_RCTL, 8'h01);
        poll(0, 0, rg_cmpl + 1, "R5 register read valid");
        rd_word(OFS_RRD0, w); chk(w == 32'h44332211, "R5 register read data", w, 32'h44332211);
        cov_is(8'hD3, "R11 register read and host read flags");

        // partial-lane write: only lanes 1 and 3
        rg_wait_cfg = 1;
        rgq.push_back('{1, 9, 32'hCD33AB11, 4'b1010, "R2 partial lanes"});
        hwr(OFS_RIDX, 8'h09);
        hwr(OFS_RWD0 + 5'd1, 8'hAB); hwr(OFS_RWD0 + 5'd3, 8'hCD);
        poll(0, 1, rg_cmpl + 1, "R4 partial write done");
        rgq.push_back('{0, 9, 0, 0, "R2 read idx9"});
        hwr(OFS_RCTL, 8'h01);
        poll(0, 0, rg_cmpl + 1, "R5 read valid idx9");
        rd_word(OFS_RRD0, w); chk(w == 32'hCDDEAB09, "R2 disabled lanes kept", w, 32'hCDDEAB09);
        cov_is(8'hDB, "R11 partial-lane flag");

        // memory write to page 2, address 0x1234
        mm_wait_cfg = 0;
        mmq.push_back('{1, 2 * 2048 + (16'h1234 % 2048), 32'hDEADBEEF, 4'hF, "R6 page 2 write"});
        hwr(OFS_MADL, 8'h34); hwr(OFS_MADH, 8'h12); hwr(OFS_PAGE, 8'h02);
        hwr(OFS_MWD0, 8'hEF); hwr(OFS_MWD0 + 5'd1, 8'hBE);
        hwr(OFS_MWD0 + 5'd2, 8'hAD); hwr(OFS_MWD0 + 5'd3, 8'hDE);
        poll(1, 1, mm_cmpl + 1, "R4 memory write done");
        mm_wait_cfg = 4;
        mmq.push_back('{0, 2 * 2048 + (16'h1234 % 2048), 0, 0, "R6 page 2 read"});
        hwr(OFS_MCTL, 8'h01);
        poll(1, 0, mm_cmpl + 1, "R5 memory read valid");
        rd_word(OFS_MRD0, w); chk(w == 32'hDEADBEEF, "R6 memory read data", w, 32'hDEADBEEF);
        cov_is(8'hFF, "R11 memory flags");

        // last location of page 3
        mmq.push_back('{0, 8191, 0, 0, "R6 page 3 top"});
        hwr(OFS_PAGE, 8'h03); hwr(OFS_MADL, 8'hFF); hwr(OFS_MADH, 8'hFF);
        hwr(OFS_MCTL, 8'h01);
        poll(1, 0, mm_cmpl + 1, "R5 memory read valid page 3");
        rd_word(OFS_MRD0, w); chk(w == (32'h5A000000 | (8191 * 7)), "R6 page 3 location 8191", w, 32'h5A000000 | (8191 * 7));

        // page 0, address bits above the page size wrap
        mm_wait_cfg = 1;
        mmq.push_back('{0, 0, 0, 0, "R6 upper address bits ignored"});
        hwr(OFS_PAGE, 8'h00); hwr(OFS_MADL, 8'h00); hwr(OFS_MADH, 8'h08);
        hwr(OFS_MCTL, 8'h01);
        poll(1, 0, mm_cmpl + 1, "R5 memory read valid page 0");
        rd_word(OFS_MRD0, w); chk(w == 32'h5A000000, "R6 location 0", w, 32'h5A000000);

        // hold-off and priority: three requests behind a long register read
        kind_log.delete();
        rg_wait_cfg = 6; mm_wait_cfg = 2;
        rgq.push_back('{0, 9, 0, 0, "R7 read in flight"});
        rgq.push_back('{1, 9, 32'h7733AB11, 4'b1000, "R2 R8 queued register write"});
        mmq.push_back('{1, 0, 32'hDEADBEEF, 4'hF, "R8 queued memory write"});
        mmq.push_back('{0, 0, 0, 0, "R8 queued memory read"});
        begin
            int rb, mb;
            rb = rg_cmpl; mb = mm_cmpl;
            hwr(OFS_RCTL, 8'h01);
            hwr(OFS_MCTL, 8'h01);
            hwr(OFS_MWD0 + 5'd3, 8'hDE);
            hwr(OFS_RWD0 + 5'd3, 8'h77);
            poll(0, 1, rb + 2, "R4 R7 held register write done");
            poll(1, 1, mb + 1, "R4 R7 held memory write done");
            poll(1, 0, mb + 2, "R5 R7 held memory read valid");
        end
        chk(kind_log.size() == 4, "R8 issue count", kind_log.size(), 4);
        if (kind_log.size() == 4) begin
            chk(kind_log[0] == KI_RRD, "R8 first issued", kind_log[0], KI_RRD);
            chk(kind_log[1] == KI_RWR, "R8 second issued", kind_log[1], KI_RWR);
            chk(kind_log[2] == KI_MWR, "R8 third issued", kind_log[2], KI_MWR);
            chk(kind_log[3] == KI_MRD, "R8 fourth issued", kind_log[3], KI_MRD);
        end
        rd_word(OFS_RRD0, w); chk(w == 32'hCDDEAB09, "R5 read data before queued write", w, 32'hCDDEAB09);
        rd_word(OFS_MRD0, w); chk(w == 32'hDEADBEEF, "R8 memory read after memory write", w, 32'hDEADBEEF);

        // disabling keeps flags; flag bits not writable
        hwr(OFS_COV, 8'h00);
        cov_is(8'hFE, "R9 flags sticky after disable");
        hwr(OFS_RIDX, 8'h01);
        hrd(OFS_RIDX, v);
        cov_is(8'hFE, "R10 disabled flags unchanged");
        hwr(OFS_COV, 8'h01); hwr(OFS_COV, 8'h01);
        cov_is(8'hFF, "R9 flag bits ignore writes");
        chk(rgq.size() == 0 && mmq.size() == 0, "R7 all expected requests issued", rgq.size() + mmq.size(), 0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule